// File: doc/BRIEF.md
# Serial Register Front End for a Dual-Channel DAC

This block is the serial control port of a two-channel digital-to-analog converter. A host lowers the frame-select line, clocks 24 bits in on the data line (most significant first, one bit taken on every falling edge of the serial clock), and raises frame-select again. Only then, and only if exactly 24 bits arrived, does the block act on the frame. A write frame updates one register of a small register file. A read frame queues the addressed register for return on the serial data output during the following frame.

The serial pins are brought into the system clock domain through two-flop synchronizers and edge-detected there. The system clock must therefore run at least four times faster than the serial clock. The serial link carries no back-pressure: a frame is accepted whole or discarded whole, and the host paces transfers through frame-select alone. The register contents are presented as plain parallel outputs for the converter core. Two inputs set the channel reset values: a reset-select pin, and the RESOLUTION parameter (16, 14 or 12 bits), which also fixes the device identifier and the data alignment.

Top module: `dac_spi_regif`

## Requirements
- R1: A frame is 24 bits taken MSB first on falling SCLK edges while sync_n is low. Bit 23 is the direction (1 = read, 0 = write), bits 22..16 are a 7-bit register address and bits 15..0 are the data word.
- R2: Nothing changes while a frame is in progress. A write takes effect only after the rising edge of sync_n that closes the frame.
- R3: A frame closed after any count of falling SCLK samples other than 24 is discarded: no register changes, and nothing is queued for readback.
- R4: The writable registers store the data word at these addresses: 2 sync, 3 config, 4 gain, 5 trigger, 6 broadcast, 8 channel A, 9 channel B. Each appears on its output port.
- R5: Writes to address 0 (no-op), 1 (device ID), 7 (status) and to any address above 9 change no register.
- R6: After reset, sync reads 0300h, gain reads 0003h, and config, trigger, no-op and status read 0000h.
- R7: After reset, broadcast and both channel registers hold 0000h when rst_sel is 0 and 8000h when rst_sel is 1.
- R8: The device ID register (address 1) reads 0214h, 1214h or 2214h for RESOLUTION 16, 14 or 12.
- R9: Data stored in broadcast and the channel registers has its unused LSBs forced to zero: none at 16 bits, bits 1:0 at 14 bits, bits 3:0 at 12 bits.
- R10: A write to broadcast (address 6) also loads the same word into channel A and channel B.
- R11: After a valid read frame, the next frame presents the addressed register on sdo, MSB first, advancing after each falling SCLK sample, followed by zeros. Unmapped addresses read as 0000h. sdo is 0 while sync_n is high. A frame that is not a valid read leaves nothing queued for the frame after it.
- R12: SCLK and SDIN are ignored while sync_n is high. Clock edges between frames neither shift the queued readback word nor count toward a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_sel | input | 1 | Chooses zero (0) or midscale (1) as the channel reset value |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, free-running or gated |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial readback data |
| chan_a_code | output | 16 | Channel A data register |
| chan_b_code | output | 16 | Channel B data register |
| sync_word | output | 16 | Sync register |
| config_word | output | 16 | Config register |
| gain_word | output | 16 | Gain register |
| trigger_word | output | 16 | Trigger register |
| bcast_word | output | 16 | Broadcast register |

## Verification
The bench sends frames of 7, 16, 23, 25 and 30 bits. A design that acts on short or long frames would corrupt registers that should not change. It also samples a channel output after the 24th bit but before sync_n rises, which catches a write committed too early. The bench writes to the read-only and unmapped addresses, and it checks broadcast fan-out and LSB masking at 14-bit resolution, so that a design with a missing or wrong address decode shows a changed register. It captures readback bit by bit after SCLK has toggled while sync_n is high, so a shift register that moves between frames returns a rotated word.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;

  localparam int FRAME_W = 24;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 7;
  localparam int NUM_CH  = 2;
  localparam int NUM_CTL = 4;

  localparam logic [ADDR_W-1:0] ADDR_NOOP  = 7'h0;
  localparam logic [ADDR_W-1:0] ADDR_ID    = 7'h1;
  localparam logic [ADDR_W-1:0] ADDR_SYNC  = 7'h2;
  localparam logic [ADDR_W-1:0] ADDR_CFG   = 7'h3;
  localparam logic [ADDR_W-1:0] ADDR_GAIN  = 7'h4;
  localparam logic [ADDR_W-1:0] ADDR_TRIG  = 7'h5;
  localparam logic [ADDR_W-1:0] ADDR_BCAST = 7'h6;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 7'h7;
  localparam logic [ADDR_W-1:0] ADDR_CHA   = 7'h8;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  // Device identifier per converter resolution
  function automatic logic [DATA_W-1:0] devid_for(input int res);
    case (res)
      16:      return 16'h0214;
      14:      return 16'h1214;
      default: return 16'h2214;
    endcase
  endfunction

  // Don't-care LSBs of an MSB-aligned code
  function automatic logic [DATA_W-1:0] lsb_mask(input int res);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++)
      if (i < DATA_W - res) m[i] = 1'b1;
    return m;
  endfunction

  // Control register slot -> address
  function automatic logic [ADDR_W-1:0] ctl_addr(input int idx);
    return ADDR_SYNC + ADDR_W'(idx);
  endfunction

  // Control register slot -> reset value (sync, config, gain, trigger)
  function automatic logic [DATA_W-1:0] ctl_reset(input int idx);
    case (idx)
      0:       return 16'h0300;
      2:       return 16'h0003;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import dac_spi_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_n_s,
  input  logic   sclk_s,
  input  logic   sdin_s,
  output logic   sample_stb,
  output logic   frame_end,
  output logic   frame_ok,
  output frame_t frm
);

  localparam int CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FW + 1);

  logic             sclk_q, sync_q;
  logic             sclk_fall, sync_fall, sync_rise;
  logic [CNT_W-1:0] cnt;
  logic [FW-1:0]    sh;

  assign sclk_fall  = sclk_q & ~sclk_s;
  assign sync_fall  = sync_q & ~sync_n_s;
  assign sync_rise  = ~sync_q & sync_n_s;
  assign sample_stb = sclk_fall & ~sync_n_s & ~sync_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sync_q <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      sync_q <= sync_n_s;
    end
  end

  // Bit counter saturates one past a full frame so long frames are seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (sync_fall) begin
      cnt <= '0;
      sh  <= '0;
    end else if (sample_stb) begin
      sh <= {sh[FW-2:0], sdin_s};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_end <= 1'b0;
      frame_ok  <= 1'b0;
      frm       <= '0;
    end else begin
      frame_end <= sync_rise;
      if (sync_rise) begin
        frame_ok <= (cnt == CNT_FULL);
        frm      <= frame_t'(sh);
      end
    end
  end

endmodule

// File: rtl/dac_regfile.sv
module dac_regfile
  import dac_spi_pkg::*;
#(
  parameter int RESOLUTION = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rst_sel,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic [NUM_CH-1:0][DATA_W-1:0] chan_q,
  output logic [NUM_CTL-1:0][DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0]            bcast_q
);

  localparam logic [DATA_W-1:0] MASK  = lsb_mask(RESOLUTION);
  localparam logic [DATA_W-1:0] DEVID = devid_for(RESOLUTION);

  logic [DATA_W-1:0] rst_word;
  logic [DATA_W-1:0] code_m;
  logic              bcast_hit;

  assign rst_word  = rst_sel ? 16'h8000 : 16'h0000;
  assign code_m    = wr_data & ~MASK;
  assign bcast_hit = wr_en && (wr_addr == ADDR_BCAST);

  // Plain control registers
  for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
    localparam logic [ADDR_W-1:0] MY_ADDR = ctl_addr(c);
    localparam logic [DATA_W-1:0] MY_RST  = ctl_reset(c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             ctl_q[c] <= MY_RST;
      else if (wr_en && (wr_addr == MY_ADDR)) ctl_q[c] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bcast_q <= rst_word;
    else if (bcast_hit) bcast_q <= code_m;
  end

  // Channel data registers, each also loaded by a broadcast write
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_CHA + ADDR_W'(ch);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        chan_q[ch] <= rst_word;
      else if (bcast_hit || (wr_en && (wr_addr == MY_ADDR)))
        chan_q[ch] <= code_m;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_NOOP:  rd_data = '0;
      ADDR_ID:    rd_data = DEVID;
      ADDR_SYNC:  rd_data = ctl_q[0];
      ADDR_CFG:   rd_data = ctl_q[1];
      ADDR_GAIN:  rd_data = ctl_q[2];
      ADDR_TRIG:  rd_data = ctl_q[3];
      ADDR_BCAST: rd_data = bcast_q;
      ADDR_STAT:  rd_data = '0;
      default: begin
        for (int ch = 0; ch < NUM_CH; ch++)
          if (rd_addr == ADDR_CHA + ADDR_W'(ch)) rd_data = chan_q[ch];
      end
    endcase
  end

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import dac_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              shift,
  input  logic              active,
  output logic              sdo
);

  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= load_val;
    else if (shift) sh <= {sh[DATA_W-2:0], 1'b0};
  end

  assign sdo = active & sh[DATA_W-1];

endmodule

// File: rtl/dac_spi_regif.sv
module dac_spi_regif
  import dac_spi_pkg::*;
#(
  parameter int RESOLUTION  = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_sel,
  input  logic        sync_n,
  input  logic        sclk,
  input  logic        sdin,
  output logic        sdo,
  output logic [15:0] chan_a_code,
  output logic [15:0] chan_b_code,
  output logic [15:0] sync_word,
  output logic [15:0] config_word,
  output logic [15:0] gain_word,
  output logic [15:0] trigger_word,
  output logic [15:0] bcast_word
);

  logic [2:0]  pins_s;
  logic        sync_n_s, sclk_s, sdin_s;
  logic        sample_stb, frame_end, frame_ok;
  frame_t      frm;
  logic        wr_en;
  logic [DATA_W-1:0] rd_data, tx_val;
  logic [NUM_CH-1:0][DATA_W-1:0]  chan_q;
  logic [NUM_CTL-1:0][DATA_W-1:0] ctl_q;

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sync_n, sclk, sdin}), .q(pins_s)
  );
  assign {sync_n_s, sclk_s, sdin_s} = pins_s;

  spi_frame_rx #(.FW(FRAME_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sync_n_s(sync_n_s), .sclk_s(sclk_s),
    .sdin_s(sdin_s), .sample_stb(sample_stb), .frame_end(frame_end),
    .frame_ok(frame_ok), .frm(frm)
  );

  assign wr_en = frame_end & frame_ok & ~frm.rd;

  dac_regfile #(.RESOLUTION(RESOLUTION)) u_regs (
    .clk(clk), .rst_n(rst_n), .rst_sel(rst_sel), .wr_en(wr_en),
    .wr_addr(frm.addr), .wr_data(frm.data), .rd_addr(frm.addr),
    .rd_data(rd_data), .chan_q(chan_q), .ctl_q(ctl_q), .bcast_q(bcast_word)
  );

  assign tx_val = (frame_ok & frm.rd) ? rd_data : '0;

  spi_tx_shift u_tx (
    .clk(clk), .rst_n(rst_n), .load(frame_end), .load_val(tx_val),
    .shift(sample_stb), .active(~sync_n_s), .sdo(sdo)
  );

  assign chan_a_code  = chan_q[0];
  assign chan_b_code  = chan_q[1];
  assign sync_word    = ctl_q[0];
  assign config_word  = ctl_q[1];
  assign gain_word    = ctl_q[2];
  assign trigger_word = ctl_q[3];

endmodule

// File: rtl/dac_spi_regif_chk.sv
module dac_spi_regif_chk
  import dac_spi_pkg::*;
#(
  parameter int RESOLUTION = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_sel,
  input logic              frame_end,
  input logic              frame_ok,
  input frame_t            frm,
  input logic [DATA_W-1:0] chan_a_code,
  input logic [DATA_W-1:0] chan_b_code,
  input logic [DATA_W-1:0] bcast_word
);

  localparam logic [DATA_W-1:0] MASK = lsb_mask(RESOLUTION);

  // R2: channel data moves only in the cycle after a frame closes
  assert_commit_on_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> ($stable(chan_a_code) && $stable(chan_b_code) && $stable(bcast_word)));

  // R3: a frame of the wrong length leaves the channels untouched
  assert_bad_frame_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !frame_ok) |=> ($stable(chan_a_code) && $stable(chan_b_code)));

  // R7: reset value of the channels follows rst_sel
  assert_reset_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (chan_a_code == (rst_sel ? 16'h8000 : 16'h0000)));

  // R9: unused LSBs of stored codes stay clear
  assert_lsb_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_a_code & MASK) == '0) && ((chan_b_code & MASK) == '0));

  // R10: a broadcast write leaves both channels equal to the broadcast word
  assert_bcast_fanout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && frame_ok && !frm.rd && frm.addr == ADDR_BCAST)
      |=> (chan_a_code == chan_b_code && chan_a_code == bcast_word));

endmodule

bind dac_spi_regif dac_spi_regif_chk #(.RESOLUTION(RESOLUTION)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sel(rst_sel), .frame_end(frame_end),
  .frame_ok(frame_ok), .frm(frm), .chan_a_code(chan_a_code),
  .chan_b_code(chan_b_code), .bcast_word(bcast_word)
);

// File: tb/dac_spi_regif_test.sv
module dac_spi_regif_test;

  localparam int RES = 14;
  localparam logic [15:0] MASK = 16'h0003;
  localparam logic [15:0] DEVID = 16'h1214;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_sel = 1'b0;
  logic sync_n = 1'b1;
  logic sclk = 1'b0;
  logic sdin = 1'b0;
  logic sdo;
  logic [15:0] chan_a_code, chan_b_code, sync_word, config_word;
  logic [15:0] gain_word, trigger_word, bcast_word;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  // model state
  logic [15:0] m_sync, m_cfg, m_gain, m_trig, m_bcast, m_a, m_b;
  logic [15:0] m_tx;

  dac_spi_regif #(.RESOLUTION(RES)) uut (
    .clk(clk), .rst_n(rst_n), .rst_sel(rst_sel), .sync_n(sync_n),
    .sclk(sclk), .sdin(sdin), .sdo(sdo), .chan_a_code(chan_a_code),
    .chan_b_code(chan_b_code), .sync_word(sync_word),
    .config_word(config_word), .gain_word(gain_word),
    .trigger_word(trigger_word), .bcast_word(bcast_word)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000 && !done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [6:0] a);
    case (a)
      7'd1: return DEVID;
      7'd2: return m_sync;
      7'd3: return m_cfg;
      7'd4: return m_gain;
      7'd5: return m_trig;
      7'd6: return m_bcast;
      7'd8: return m_a;
      7'd9: return m_b;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic void m_write(input logic [6:0] a, input logic [15:0] d);
    case (a)
      7'd2: m_sync = d;
      7'd3: m_cfg  = d;
      7'd4: m_gain = d;
      7'd5: m_trig = d;
      7'd6: begin m_bcast = d & ~MASK; m_a = d & ~MASK; m_b = d & ~MASK; end
      7'd8: m_a = d & ~MASK;
      7'd9: m_b = d & ~MASK;
      default: ;
    endcase
  endfunction

  function automatic void m_reset(input logic sel);
    m_sync = 16'h0300; m_cfg = 16'h0000; m_gain = 16'h0003; m_trig = 16'h0000;
    m_bcast = sel ? 16'h8000 : 16'h0000;
    m_a = m_bcast; m_b = m_bcast; m_tx = 16'h0000;
  endfunction

  task automatic check_regs(input string req);
    chk({req, " chan_a"},  {16'h0, chan_a_code},  {16'h0, m_a});
    chk({req, " chan_b"},  {16'h0, chan_b_code},  {16'h0, m_b});
    chk({req, " sync"},    {16'h0, sync_word},    {16'h0, m_sync});
    chk({req, " config"},  {16'h0, config_word},  {16'h0, m_cfg});
    chk({req, " gain"},    {16'h0, gain_word},    {16'h0, m_gain});
    chk({req, " trigger"}, {16'h0, trigger_word}, {16'h0, m_trig});
    chk({req, " bcast"},   {16'h0, bcast_word},   {16'h0, m_bcast});
  endtask

  task automatic do_reset(input logic sel);
    rst_n = 1'b0; rst_sel = sel; sync_n = 1'b1; sclk = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    m_reset(sel);
  endtask

  // Sends nbits of w (MSB first, zeros past bit 24), captures sdo,
  // optionally checks channel A after the last bit but before sync_n rises.
  task automatic send(input logic [23:0] w, input int nbits, input bit midcheck,
                      output logic [23:0] got);
    got = '0;
    sync_n = 1'b0;
    tick(4);
    for (int i = 0; i < nbits; i++) begin
      sdin = (i < 24) ? w[23-i] : 1'b0;
      sclk = 1'b1;
      tick(4);
      if (i < 24) got = {got[22:0], sdo};
      sclk = 1'b0;
      tick(4);
    end
    if (midcheck) begin
      tick(8);
      chk("R2 no write before sync_n rises", {16'h0, chan_a_code}, {16'h0, m_a});
    end
    sync_n = 1'b1;
    tick(8);
  endtask

  // One frame with the model kept in step
  task automatic frame(input bit rd, input logic [6:0] a, input logic [15:0] d,
                       input int nbits, input string req);
    logic [23:0] got;
    logic [15:0] exp_tx;
    exp_tx = m_tx;
    send({rd, a, d}, nbits, 1'b0, got);
    if (nbits == 24)
      chk({req, " R11 sdo"}, {8'h0, got}, {8'h0, exp_tx, 8'h00});
    if (nbits == 24 && rd) m_tx = m_read(a);
    else m_tx = 16'h0000;
    if (nbits == 24 && !rd) m_write(a, d);
    check_regs(req);
  endtask

  initial begin
    logic [23:0] got;
    void'($urandom(32'd20240611));

    // R7 midscale reset, R6 reset values
    do_reset(1'b1);
    check_regs("R7 rst_sel=1 / R6");
    chk("R11 sdo idle low", {31'h0, sdo}, 32'h0);
    do_reset(1'b0);
    check_regs("R7 rst_sel=0 / R6");

    // R8 device ID read, returned in the following frame
    frame(1'b1, 7'd1, 16'h0000, 24, "R8 id read");
    frame(1'b1, 7'd7, 16'h0000, 24, "R8 id readout / status read");
    frame(1'b0, 7'd0, 16'h0000, 24, "R6 status reads zero");

    // R4 plain writes
    frame(1'b0, 7'd2, 16'hA5C3, 24, "R4 sync write");
    frame(1'b0, 7'd3, 16'h1234, 24, "R4 config write");
    frame(1'b0, 7'd4, 16'h0001, 24, "R4 gain write");
    frame(1'b0, 7'd5, 16'h0010, 24, "R4 trigger write");
    frame(1'b0, 7'd8, 16'hFFFF, 24, "R9 chan A masked");
    frame(1'b0, 7'd9, 16'h7FFE, 24, "R9 chan B masked");

    // R10 broadcast fan-out
    frame(1'b0, 7'd6, 16'hC0DF, 24, "R10 broadcast");

    // R5 ignored addresses
    frame(1'b0, 7'd0, 16'hFFFF, 24, "R5 noop write");
    frame(1'b0, 7'd1, 16'hFFFF, 24, "R5 id write");
    frame(1'b0, 7'd7, 16'hFFFF, 24, "R5 status write");
    frame(1'b0, 7'd10, 16'hFFFF, 24, "R5 unmapped write");
    frame(1'b0, 7'h7F, 16'hFFFF, 24, "R5 top address write");
    frame(1'b1, 7'd1, 16'h0000, 24, "R5 id read back");
    frame(1'b1, 7'd12, 16'h0000, 24, "R11 id value / unmapped read");
    frame(1'b0, 7'd0, 16'h0000, 24, "R11 unmapped reads zero");

    // R3 wrong-length frames
    frame(1'b0, 7'd8, 16'h1110, 23, "R3 23-bit frame");
    frame(1'b0, 7'd8, 16'h2220, 25, "R3 25-bit frame");
    frame(1'b0, 7'd9, 16'h3330, 7, "R3 7-bit frame");
    frame(1'b1, 7'd2, 16'h0000, 16, "R3 short read");
    frame(1'b0, 7'd0, 16'h0000, 24, "R3 nothing queued");

    // R2 mid-frame probe
    send({1'b0, 7'd8, 16'h4444}, 24, 1'b1, got);
    m_write(7'd8, 16'h4444); m_tx = 16'h0000;
    check_regs("R2 commit after close");

    // R12 idle clocks must not shift the queued word
    frame(1'b1, 7'd2, 16'h0000, 24, "R12 queue sync");
    for (int i = 0; i < 5; i++) begin
      sdin = 1'b1; sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    end
    chk("R12 sdo low between frames", {31'h0, sdo}, 32'h0);
    frame(1'b0, 7'd0, 16'h0000, 24, "R12 readout after idle clocks");

    // Random traffic
    for (int k = 0; k < 80; k++) begin
      logic [6:0]  a;
      logic [15:0] d;
      bit          rd;
      int          nb;
      a  = 7'($urandom_range(0, 15));
      d  = 16'($urandom());
      rd = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 9))
        0: nb = 23;
        1: nb = 25;
        2: nb = 30;
        default: nb = 24;
      endcase
      frame(rd, a, d, nb, "R1 random frame");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule